// File: doc/BRIEF.md
# Windowed Serial Audio Output Serializer

This block turns six stereo channel accumulators into a serial audio stream. It runs on a system clock and advances only on a one-cycle `bit_tick` pulse, which marks a falling edge of a free-running bit clock. Internally it produces a left/right frame clock whose half-frame length can be programmed, and a per-half-frame bit counter. Inside each half-frame the counter opens a programmable window, and the block marks that window with a word clock.

At the start of the window in the high half of the frame, all twelve sums are captured and clipped to a signed 20-bit range. Inside each window, every data line shifts one clipped sample out, most significant bit first. The high half carries the right sample and the low half carries the left sample captured at the same moment. Window start and end values are taken on the rising frame-clock edge. The half-frame length is taken on the falling edge.

A global enable forces the word clock and the data lines low. The frame clock and the counters keep running while the enable is low.

Top module: `serial_audio_tx`

## Requirements
- R1: The frame clock `lrck` changes only on a `bit_tick` pulse. A half-frame lasts the latched length plus one ticks. The length resets to 31.
- R2: `cfg_half` is sampled only on the tick where `lrck` falls, so changing it during a high half does not alter that half.
- R3: `cfg_start` and `cfg_end` are sampled only on the tick where `lrck` rises. Both halves of a frame use the same pair.
- R4: Index the ticks of a half-frame from 0, where 0 is the tick that toggled `lrck`. After tick k, `wclk` is high exactly when start <= k < end.
- R5: Each 23-bit signed sum is clipped to the range -524288 to 524287 and sent as a 20-bit two's-complement word.
- R6: After tick start+j, for j from 0 to 19, `sdata[i]` carries bit 19-j of channel i's word. After 20 bits the line stays low, even if the window is still open. Outside a window the line is low.
- R7: A window shorter than 20 ticks sends only the upper bits of the word and drops the rest.
- R8: In the high half the right word is sent and in the low half the left word is sent. Both words are snapshotted at the start tick of the high half, so input changes after that tick reach the lines only in the next frame.
- R9: While `run` is low, `wclk` and `sdata` are low. The frame clock and the counters keep advancing.
- R10: After reset, `lrck`, `wclk` and `sdata` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Global enable for word clock and data lines |
| bit_tick | input | 1 | One-cycle pulse per bit-clock falling edge |
| cfg_start | input | 7 | Window start index |
| cfg_end | input | 7 | Window end index (exclusive) |
| cfg_half | input | 7 | Half-frame length minus one |
| sum_left | input | 6*23 | Packed signed left sums, channel i at bits [23i+22:23i] |
| sum_right | input | 6*23 | Packed signed right sums, same packing |
| lrck | output | 1 | Left/right frame clock |
| wclk | output | 1 | Word clock marking the bit window |
| sdata | output | 6 | Serial data, one line per channel |

## Verification
The properties assume a few things about the inputs. Start is below end, end does not exceed the half-frame length in effect, and `bit_tick` is a single-cycle pulse. Without these, a window could remain open across a frame-clock toggle. The stimulus keeps the half-frame length at 39 whenever windows reach past index 15. It only shortens the half-frame to 16 ticks while the window end is 10. Inputs and configuration change only between ticks.

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int CH       = 6,
  parameter int SUM_W    = 23,
  parameter int OUT_W    = 20,
  parameter int CFG_W    = 7,
  parameter int RST_HALF = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  bit_tick,
  input  logic [CFG_W-1:0]      cfg_start,
  input  logic [CFG_W-1:0]      cfg_end,
  input  logic [CFG_W-1:0]      cfg_half,
  input  logic [CH*SUM_W-1:0]   sum_left,
  input  logic [CH*SUM_W-1:0]   sum_right,
  output logic                  lrck,
  output logic                  wclk,
  output logic [CH-1:0]         sdata
);
  localparam int PTR_W = $clog2(OUT_W + 1);
  localparam logic signed [SUM_W-1:0] POS_LIM = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] NEG_LIM = {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic [OUT_W-1:0] clip(input logic signed [SUM_W-1:0] v);
    if (v > POS_LIM)      clip = POS_LIM[OUT_W-1:0];
    else if (v < NEG_LIM) clip = NEG_LIM[OUT_W-1:0];
    else                  clip = v[OUT_W-1:0];
  endfunction

  logic             lr_q, wclk_q, side_q;
  logic [CFG_W-1:0] lr_cnt_q, len_q, st_q, end_q, wc_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CH-1:0]    sd_q;
  logic [OUT_W-1:0] hold_l [CH];
  logic [OUT_W-1:0] hold_r [CH];
  logic [OUT_W-1:0] sat_l  [CH];
  logic [OUT_W-1:0] sat_r  [CH];

  logic             toggle, lr_n, rise, fall, hit_st, hit_end, snap, shift, side_e;
  logic [CFG_W-1:0] wc_e, st_e, end_e;
  logic [PTR_W-1:0] ptr_e, bit_idx;
  logic [CH-1:0]    sd_n;

  assign toggle  = (lr_cnt_q == len_q);
  assign lr_n    = lr_q ^ toggle;
  assign rise    = toggle & ~lr_q;
  assign fall    = toggle & lr_q;
  assign wc_e    = toggle ? '0 : wc_q;
  assign st_e    = rise ? cfg_start : st_q;
  assign end_e   = rise ? cfg_end : end_q;
  assign hit_st  = (wc_e == st_e);
  assign hit_end = (wc_e == end_e);
  assign snap    = hit_st & lr_n;
  assign side_e  = hit_st ? lr_n : side_q;
  assign ptr_e   = hit_st ? PTR_W'(OUT_W) : ptr_q;
  assign bit_idx = ptr_e - 1'b1;
  assign shift   = (wc_e >= st_e) && (wc_e < end_e) && (ptr_e != '0);

  for (genvar i = 0; i < CH; i++) begin : g_ch
    assign sat_l[i] = clip(sum_left[i*SUM_W +: SUM_W]);
    assign sat_r[i] = clip(sum_right[i*SUM_W +: SUM_W]);
    logic [OUT_W-1:0] cur_l, cur_r;
    assign cur_l   = snap ? sat_l[i] : hold_l[i];
    assign cur_r   = snap ? sat_r[i] : hold_r[i];
    assign sd_n[i] = shift & (side_e ? cur_r[bit_idx] : cur_l[bit_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q <= 1'b0; lr_cnt_q <= '0; len_q <= CFG_W'(RST_HALF);
      st_q <= '0; end_q <= '0; wc_q <= '0; wclk_q <= 1'b0;
      ptr_q <= '0; side_q <= 1'b0; sd_q <= '0;
      for (int i = 0; i < CH; i++) begin hold_l[i] <= '0; hold_r[i] <= '0; end
    end else if (bit_tick) begin
      lr_q     <= lr_n;
      lr_cnt_q <= toggle ? '0 : lr_cnt_q + 1'b1;
      if (fall) len_q <= cfg_half;
      if (rise) begin st_q <= cfg_start; end_q <= cfg_end; end
      wc_q <= wc_e + 1'b1;
      if (hit_st)  wclk_q <= 1'b1;
      if (hit_end) wclk_q <= 1'b0;
      ptr_q  <= shift ? ptr_e - 1'b1 : ptr_e;
      side_q <= side_e;
      sd_q   <= sd_n;
      if (snap)
        for (int i = 0; i < CH; i++) begin hold_l[i] <= sat_l[i]; hold_r[i] <= sat_r[i]; end
    end
  end

  assign lrck  = lr_q;
  assign wclk  = wclk_q & run;
  assign sdata = sd_q & {CH{run}};

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(lr_q) && $stable(wc_q) && $stable(sd_q));
  p_toggle_len_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && lr_cnt_q != len_q) |=> $stable(lr_q));
  p_len_at_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$fell(lr_q) |-> $stable(len_q));
  p_win_at_rise_r3: assert property (@(posedge clk) disable iff (rst)
    !$rose(lr_q) |-> $stable(st_q) && $stable(end_q));
  p_data_in_window_r6: assert property (@(posedge clk) disable iff (rst)
    (sd_q != '0) |-> wclk_q);
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_W'(OUT_W));
endmodule

// File: tb/test_serial_audio_tx.sv
`timescale 1ns/1ps
module test_serial_audio_tx;
  localparam int CH = 6, SW = 23;
  logic clk = 1'b0, rst = 1'b1, run = 1'b1, bit_tick = 1'b0;
  logic [6:0] cfg_start = 7'd0, cfg_end = 7'd0, cfg_half = 7'd39;
  logic [CH*SW-1:0] sum_left = '0, sum_right = '0;
  logic lrck, wclk;
  logic [CH-1:0] sdata;

  serial_audio_tx i_serial_audio_tx (
    .clk(clk), .rst(rst), .run(run), .bit_tick(bit_tick),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_half(cfg_half),
    .sum_left(sum_left), .sum_right(sum_right),
    .lrck(lrck), .wclk(wclk), .sdata(sdata));

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  int inl[CH], inr[CH], mL[CH], mR[CH];
  int k = -1, mS = 0, mE = 0, cur_len = 31, toggles = 0;
  logic prev_lr = 1'b0, seen = 1'b0;
  string tag_l = "R1", tag_w = "R4", tag_d = "R6";

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", tag, act, exp, k);
    end
  endtask

  function automatic int sat(int v);
    if (v > 524287) v = 524287;
    if (v < -524288) v = -524288;
    return v & 32'hFFFFF;
  endfunction

  task automatic drive_in();
    for (int i = 0; i < CH; i++) begin
      sum_left[i*SW +: SW]  = inl[i][SW-1:0];
      sum_right[i*SW +: SW] = inr[i][SW-1:0];
    end
  endtask

  task automatic tick();
    logic [CH-1:0] exp_sd;
    logic win;
    bit_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    bit_tick = 1'b0;
    if (lrck !== prev_lr) begin
      if (seen) chk(tag_l, k + 1, cur_len + 1);
      seen = 1'b1;
      if (lrck) begin mS = cfg_start; mE = cfg_end; end
      else cur_len = cfg_half;
      k = 0; prev_lr = lrck; toggles++;
    end else k++;
    if (lrck && k == mS)
      for (int i = 0; i < CH; i++) begin mR[i] = sat(inr[i]); mL[i] = sat(inl[i]); end
    win = (k >= mS) && (k < mE);
    exp_sd = '0;
    if (run && win && (k - mS) < 20)
      for (int i = 0; i < CH; i++) begin
        int d;
        d = lrck ? mR[i] : mL[i];
        exp_sd[i] = ((d >> (19 - (k - mS))) & 1) != 0;
      end
    chk(tag_w, int'(wclk), int'(run && win));
    chk(tag_d, int'(sdata), int'(exp_sd));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_halves(int n);
    int t0;
    t0 = toggles;
    while (toggles < t0 + n) tick();
  endtask

  task automatic wait_at(logic lv, int kk);
    while (!(lrck == lv && k == kk)) tick();
  endtask

  task automatic set_vals(int base);
    for (int i = 0; i < CH; i++) begin
      inl[i] = base * (i + 1) - 3 * i;
      inr[i] = -base * (i + 2) + 7 * i;
    end
    drive_in();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int sv[4];
    int dl[4];
    for (int i = 0; i < CH; i++) begin inl[i] = 0; inr[i] = 0; mL[i] = 0; mR[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", int'(lrck), 0);
    chk("R10", int'(wclk), 0);
    chk("R10", int'(sdata), 0);
    // R1: no ticks means no progress
    repeat (20) @(negedge clk);
    chk("R1", int'(lrck), 0);
    chk("R1", int'(wclk), 0);
    run_halves(4);

    // R5: clipping of out-of-range and boundary sums
    inl = '{4194303, -4194304, 524287, -524288, 524288, -524289};
    inr = '{-1, 1, 12345, -77777, 3000000, -3000000};
    drive_in();
    cfg_start = 7'd2; cfg_end = 7'd22; tag_d = "R5";
    run_halves(6);

    // R6 / R7: sweep of window positions and lengths
    sv = '{0, 1, 3, 7};
    dl = '{4, 19, 20, 25};
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        if (sv[a] + dl[b] <= 39) begin
          cfg_start = 7'(sv[a]); cfg_end = 7'(sv[a] + dl[b]);
          tag_d = (dl[b] < 20) ? "R7" : "R6";
          tag_w = "R4";
          set_vals(30011 * (a + 1) + 977 * b);
          run_halves(5);
        end
      end

    // R8: inputs change after the snapshot tick of the high half
    cfg_start = 7'd2; cfg_end = 7'd30; tag_d = "R8"; tag_w = "R4";
    run_halves(3);
    wait_at(1'b1, 5);
    set_vals(-91234);
    run_halves(4);

    // R3: window values changed right after a falling edge
    tag_w = "R3"; tag_d = "R3";
    wait_at(1'b0, 0);
    cfg_start = 7'd6; cfg_end = 7'd26;
    run_halves(4);

    // R2: half length changed during a high half
    tag_w = "R4"; tag_d = "R6";
    cfg_start = 7'd2; cfg_end = 7'd10;
    run_halves(3);
    wait_at(1'b1, 1);
    tag_l = "R2";
    cfg_half = 7'd15;
    run_halves(5);
    cfg_half = 7'd39;
    run_halves(4);
    tag_l = "R1";

    // R9: enable dropped in the middle of a window
    cfg_start = 7'd3; cfg_end = 7'd27;
    run_halves(3);
    tag_w = "R9"; tag_d = "R9";
    wait_at(1'b1, 8);
    run = 1'b0;
    repeat (45) tick();
    run = 1'b1;
    run_halves(3);
    finish_run();
  end
endmodule